// File: doc/BRIEF.md
# Line-Coalescing Write Buffer

This block sits between a write-through data cache and the memory request port. It queues the processor's write requests, each a 32-bit address, a 32-bit data word and four byte enables. Writes that follow one another into the same cache line, each at a higher word index than the one before, are joined into a group. Each group leaves as one write burst of variable length, no longer than a line. The last beat of the burst is marked with an end-of-packet flag.

Only one memory transaction is outstanding at a time. After the last beat is accepted, the buffer waits for the write response. Only then does it release that group's entries and consider the next one. The full output lets the processor stall its writes. The empty output lets reads wait until all earlier writes have completed. An error flag in a response is latched on a sticky output, and the group's entries are retired anyway.

A burst starts when the processor presents no write in that cycle, or when the buffer is full. In a steady stream of writes, the group being built therefore stays open until the stream pauses.

Top module: `wr_coalesce_buf`

## Requirements
- R1: After reset the buffer holds no entries: buf_empty is 1, wr_full is 0, mreq_valid is 0 and err_sticky is 0.
- R2: A write is stored when wr_valid is 1 and wr_full is 0. wr_full is 1 exactly when DEPTH entries are stored. A write presented while wr_full is 1 is dropped and stores nothing.
- R3: A stored write joins the previous entry's group only when all three of these hold: it lies in the same line (address bits above bit 1+log2(WORDS_PER_LINE) are equal), its word index (address bits log2(WORDS_PER_LINE)+1 down to 2) is strictly greater than the previous entry's, and no burst has started since the previous write. In every other case it starts a new group.
- R4: Beats leave in arrival order. Each beat carries the written data and byte enables, and the written address with bits 1:0 forced to zero.
- R5: mreq_eop is 1 on the last beat of each group and on no other beat. No burst has more than WORDS_PER_LINE beats.
- R6: After the beat with mreq_eop is accepted, mreq_valid stays 0 until a write response arrives. A burst starts only when wr_valid is 0 or the buffer is full.
- R7: While mreq_valid is 1 and mreq_ready is 0, the beat on mreq_addr, mreq_data, mreq_be and mreq_eop holds steady into the next cycle.
- R8: A response with mrsp_err at 1 sets err_sticky, which stays 1 until reset. The group's entries are retired all the same.
- R9: A response (mrsp_valid at 1) that arrives while no burst is awaiting its response has no effect.
- R10: buf_empty is 1 only when no entries are stored and no burst is awaiting its response.
- R11: Entries are released only on the write response, so wr_full stays 1 while a burst is awaiting its response with DEPTH entries stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Processor write request |
| wr_addr | input | 32 | Write byte address |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Write byte enables |
| wr_full | output | 1 | Buffer full; processor must hold the write |
| buf_empty | output | 1 | No stored entries and no burst outstanding |
| mreq_valid | output | 1 | Memory write beat valid |
| mreq_ready | input | 1 | Memory port accepts the beat |
| mreq_addr | output | 32 | Beat address, word aligned |
| mreq_data | output | 32 | Beat data |
| mreq_be | output | 4 | Beat byte enables |
| mreq_eop | output | 1 | Last beat of the burst |
| mrsp_valid | input | 1 | Write response |
| mrsp_err | input | 1 | Response error flag |
| err_sticky | output | 1 | Latched response error |

## Verification
The bench builds the block with DEPTH of 6 and WORDS_PER_LINE of 4. A depth above the line length lets a full four-word line burst form and still leaves room behind it, and the buffer fills within a handful of writes. Because 6 is not a power of two, the storage pointers must wrap explicitly, and that wrap is exercised many times. With a line of four words, random addresses over three lines often give rising, falling and line-crossing sequences, so groups both close and open under every condition in R3.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
        logic              first;
    } wb_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT
    } snd_state_e;

    // line number of a byte address
    function automatic logic [ADDR_W-1:0] line_of(input logic [ADDR_W-1:0] a, input int widx_w);
        return a >> (widx_w + 2);
    endfunction

    // word index within a line
    function automatic logic [ADDR_W-1:0] word_of(input logic [ADDR_W-1:0] a, input int widx_w);
        return (a >> 2) & ((ADDR_W'(1) << widx_w) - ADDR_W'(1));
    endfunction

    // circular pointer step for any depth
    function automatic int wrap_inc(input int p, input int depth);
        return (p == depth - 1) ? 0 : p + 1;
    endfunction
endpackage

// File: rtl/wbuf_group.sv
module wbuf_group
    import wbuf_pkg::*;
#(
    parameter int WIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              close,
    input  logic [ADDR_W-1:0] push_addr,
    output logic              starts_group
);
    logic              open_q;
    logic [ADDR_W-1:0] last_q;

    always_comb begin
        starts_group = !open_q
                    || (line_of(push_addr, WIDX_W) != line_of(last_q, WIDX_W))
                    || (word_of(push_addr, WIDX_W) <= word_of(last_q, WIDX_W));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            last_q <= '0;
        end else if (close) begin
            open_q <= 1'b0;
        end else if (push) begin
            open_q <= 1'b1;
            last_q <= push_addr;
        end
    end
endmodule

// File: rtl/wbuf_store.sv
module wbuf_store
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3,
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  wb_entry_t         push_entry,
    input  logic [PTR_W-1:0]  rd_idx,
    input  logic              rel_en,
    input  logic [CNT_W-1:0]  rel_n,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [BE_W-1:0]   rd_be,
    output logic              rd_next_first,
    output logic [CNT_W-1:0]  count
);
    wb_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] tail_q;
    logic [PTR_W-1:0] nxt_idx;

    always_comb begin
        nxt_idx       = PTR_W'(wrap_inc(int'(rd_idx), DEPTH));
        rd_addr       = mem[rd_idx].addr;
        rd_data       = mem[rd_idx].data;
        rd_be         = mem[rd_idx].be;
        rd_next_first = mem[nxt_idx].first;
    end

    always_ff @(posedge clk) begin
        if (push) mem[tail_q] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tail_q <= '0;
            count  <= '0;
        end else begin
            if (push) tail_q <= PTR_W'(wrap_inc(int'(tail_q), DEPTH));
            count <= count + CNT_W'(push) - (rel_en ? rel_n : '0);
        end
    end
endmodule

// File: rtl/wbuf_sender.sv
module wbuf_sender
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic             wr_valid,
    input  logic             full,
    input  logic             next_first,
    input  logic             req_ready,
    input  logic             rsp_valid,
    input  logic             rsp_err,
    output logic             req_valid,
    output logic             req_eop,
    output logic [PTR_W-1:0] rd_idx,
    output logic             start,
    output logic             rel_en,
    output logic [CNT_W-1:0] rel_n,
    output logic             err_flag
);
    snd_state_e       st_q;
    logic [CNT_W-1:0] blen_q;
    logic             fire;

    always_comb begin
        start     = (st_q == ST_IDLE) && (count != '0) && (!wr_valid || full);
        req_valid = (st_q == ST_SEND);
        req_eop   = req_valid && (((count - blen_q) == CNT_W'(1)) || next_first);
        fire      = req_valid && req_ready;
        rel_en    = (st_q == ST_WAIT) && rsp_valid;
        rel_n     = blen_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            rd_idx   <= '0;
            blen_q   <= '0;
            err_flag <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: if (start) st_q <= ST_SEND;
                ST_SEND: if (fire) begin
                    rd_idx <= PTR_W'(wrap_inc(int'(rd_idx), DEPTH));
                    blen_q <= blen_q + CNT_W'(1);
                    if (req_eop) st_q <= ST_WAIT;
                end
                ST_WAIT: if (rsp_valid) begin
                    st_q   <= ST_IDLE;
                    blen_q <= '0;
                    if (rsp_err) err_flag <= 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wr_coalesce_buf.sv
module wr_coalesce_buf
    import wbuf_pkg::*;
#(
    parameter int WORDS_PER_LINE = 8,
    parameter int DEPTH          = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_valid,
    input  logic [31:0] wr_addr,
    input  logic [31:0] wr_data,
    input  logic [3:0]  wr_be,
    output logic        wr_full,
    output logic        buf_empty,
    output logic        mreq_valid,
    input  logic        mreq_ready,
    output logic [31:0] mreq_addr,
    output logic [31:0] mreq_data,
    output logic [3:0]  mreq_be,
    output logic        mreq_eop,
    input  logic        mrsp_valid,
    input  logic        mrsp_err,
    output logic        err_sticky
);
    localparam int WIDX_W = $clog2(WORDS_PER_LINE);
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              accept;
    logic              starts_group;
    logic              start;
    logic              next_first;
    logic              rel_en;
    logic [CNT_W-1:0]  rel_n;
    logic [CNT_W-1:0]  count;
    logic [PTR_W-1:0]  rd_idx;
    logic [ADDR_W-1:0] rd_addr;
    wb_entry_t         new_entry;

    always_comb begin
        wr_full         = (count == CNT_W'(DEPTH));
        buf_empty       = (count == '0);
        accept          = wr_valid && !wr_full;
        new_entry.addr  = wr_addr;
        new_entry.data  = wr_data;
        new_entry.be    = wr_be;
        new_entry.first = starts_group;
        mreq_addr       = rd_addr & ~32'h3;
    end

    wbuf_group #(.WIDX_W(WIDX_W)) group_i (
        .clk          (clk),
        .rst          (rst),
        .push         (accept),
        .close        (start),
        .push_addr    (wr_addr),
        .starts_group (starts_group)
    );

    wbuf_store #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) store_i (
        .clk           (clk),
        .rst           (rst),
        .push          (accept),
        .push_entry    (new_entry),
        .rd_idx        (rd_idx),
        .rel_en        (rel_en),
        .rel_n         (rel_n),
        .rd_addr       (rd_addr),
        .rd_data       (mreq_data),
        .rd_be         (mreq_be),
        .rd_next_first (next_first),
        .count         (count)
    );

    wbuf_sender #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) sender_i (
        .clk        (clk),
        .rst        (rst),
        .count      (count),
        .wr_valid   (wr_valid),
        .full       (wr_full),
        .next_first (next_first),
        .req_ready  (mreq_ready),
        .rsp_valid  (mrsp_valid),
        .rsp_err    (mrsp_err),
        .req_valid  (mreq_valid),
        .req_eop    (mreq_eop),
        .rd_idx     (rd_idx),
        .start      (start),
        .rel_en     (rel_en),
        .rel_n      (rel_n),
        .err_flag   (err_sticky)
    );
endmodule

// File: rtl/wr_coalesce_buf_chk.sv
module wr_coalesce_buf_chk #(
    parameter int WORDS_PER_LINE = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_full,
    input logic        buf_empty,
    input logic        mreq_valid,
    input logic        mreq_ready,
    input logic [31:0] mreq_addr,
    input logic [31:0] mreq_data,
    input logic [3:0]  mreq_be,
    input logic        mreq_eop,
    input logic        err_sticky
);
    localparam int BC_W = $clog2(WORDS_PER_LINE + 1) + 1;
    logic [BC_W-1:0] beats_q;
    logic            fire;

    assign fire = mreq_valid && mreq_ready;

    always_ff @(posedge clk) begin
        if (rst) beats_q <= '0;
        else if (fire) beats_q <= mreq_eop ? '0 : beats_q + BC_W'(1);
    end

    assert_burst_cap_R5: assert property (@(posedge clk) disable iff (rst)
        fire |-> (beats_q < BC_W'(WORDS_PER_LINE)));

    assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && mreq_eop) |=> !mreq_valid);

    assert_beat_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr)
            && $stable(mreq_data) && $stable(mreq_be) && $stable(mreq_eop)));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky);

    assert_word_align_R4: assert property (@(posedge clk) disable iff (rst)
        mreq_valid |-> (mreq_addr[1:0] == 2'b00));

    assert_empty_idle_R10: assert property (@(posedge clk) disable iff (rst)
        buf_empty |-> !mreq_valid);

    assert_full_not_empty_R2: assert property (@(posedge clk) disable iff (rst)
        !(wr_full && buf_empty));
endmodule

bind wr_coalesce_buf wr_coalesce_buf_chk #(.WORDS_PER_LINE(WORDS_PER_LINE)) chk_i (.*);

// File: tb/wr_coalesce_buf_tb_top.sv
module wr_coalesce_buf_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WPL        = 4;
    localparam int DEPTH      = 6;
    localparam int LSH        = 4;   // log2(WPL) + 2

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic        wr_full, buf_empty, mreq_valid, mreq_eop, err_sticky;
    logic        mreq_ready = 1'b0;
    logic [31:0] mreq_addr, mreq_data;
    logic [3:0]  mreq_be;
    logic        mrsp_valid = 1'b0;
    logic        mrsp_err = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wr_coalesce_buf #(.WORDS_PER_LINE(WPL), .DEPTH(DEPTH)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        logic [3:0]  be;
        bit          first;
    } m_ent_t;

    m_ent_t      q[$];
    int          m_st = 0;     // 0 idle, 1 sending, 2 awaiting response
    int          m_sent = 0;
    bit          m_open = 0;
    logic [31:0] m_last = '0;
    bit          m_err = 0;

    function automatic bit m_eop();
        if (m_sent + 1 >= q.size()) return 1'b1;
        return q[m_sent + 1].first;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_st = 0; m_sent = 0; m_open = 0; m_last = '0; m_err = 0;
        end else begin
            bit full_pre, acc, start, eop, nf;
            logic [31:0] wa;
            full_pre = (q.size() == DEPTH);
            acc   = wr_valid && !full_pre;
            start = (m_st == 0) && (q.size() != 0) && (!wr_valid || full_pre);
            eop   = (m_st == 1) ? m_eop() : 1'b0;
            wa    = wr_addr & ~32'h3;
            nf    = !m_open || ((wa >> LSH) != (m_last >> LSH))
                    || (((wa >> 2) & (WPL-1)) <= ((m_last >> 2) & (WPL-1)));
            if (start) m_st = 1;
            else if (m_st == 1 && mreq_ready) begin
                m_sent++;
                if (eop) m_st = 2;
            end else if (m_st == 2 && mrsp_valid) begin
                for (int i = 0; i < m_sent; i++) void'(q.pop_front());
                m_sent = 0;
                m_st = 0;
                if (mrsp_err) m_err = 1;
            end
            if (acc) q.push_back('{a: wa, d: wr_data, be: wr_be, first: nf});
            if (start) m_open = 0;
            else if (acc) begin m_open = 1; m_last = wa; end
        end
    end

    // ---------------- per-cycle comparison ----------------
    bit          hold_prev = 0;
    logic [31:0] pa, pd;
    logic [3:0]  pb;
    logic        pe;
    int          cur_len = 0;

    always @(negedge clk) begin
        if (!rst) begin
            chk(wr_full == (q.size() == DEPTH), "R2 full", 32'(wr_full), 32'(q.size() == DEPTH));
            chk(buf_empty == (q.size() == 0), "R10 empty", 32'(buf_empty), 32'(q.size() == 0));
            chk(mreq_valid == (m_st == 1), "R6 valid", 32'(mreq_valid), 32'(m_st == 1));
            chk(err_sticky == m_err, "R8 err", 32'(err_sticky), 32'(m_err));
            if (m_st == 1 && mreq_valid) begin
                chk(mreq_addr == q[m_sent].a, "R4 addr", mreq_addr, q[m_sent].a);
                chk(mreq_data == q[m_sent].d, "R4 data", mreq_data, q[m_sent].d);
                chk(mreq_be == q[m_sent].be, "R4 be", 32'(mreq_be), 32'(q[m_sent].be));
                chk(mreq_eop == m_eop(), "R3/R5 eop", 32'(mreq_eop), 32'(m_eop()));
            end
            if (hold_prev) begin
                chk(mreq_valid && mreq_addr == pa && mreq_data == pd && mreq_be == pb && mreq_eop == pe,
                    "R7 hold", mreq_addr, pa);
            end
            hold_prev = mreq_valid && !mreq_ready;
            pa = mreq_addr; pd = mreq_data; pb = mreq_be; pe = mreq_eop;
            if (mreq_valid && mreq_ready) begin
                cur_len++;
                chk(cur_len <= WPL, "R5 burst length", 32'(cur_len), 32'(WPL));
                if (mreq_eop) cur_len = 0;
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic put(input logic [31:0] a);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = $urandom;
        wr_be    = 4'($urandom);
    endtask

    task automatic wait_burst(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            wr_valid = 1'b0;
            if (mreq_valid && mreq_ready) begin
                n++;
                if (mreq_eop) break;
            end
        end
    endtask

    task automatic respond(input bit e);
        @(negedge clk);
        mrsp_valid = 1'b1;
        mrsp_err   = e;
        @(negedge clk);
        mrsp_valid = 1'b0;
        mrsp_err   = 1'b0;
    endtask

    task automatic drain();
        wr_valid   = 1'b0;
        mreq_ready = 1'b1;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            mrsp_valid = 1'b1;
            if (buf_empty) break;
        end
        mrsp_valid = 1'b0;
        @(negedge clk);
        chk(buf_empty == 1'b1, "R10 drained", 32'(buf_empty), 32'h1);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(buf_empty == 1'b1, "R1 empty", 32'(buf_empty), 32'h1);
        chk(wr_full == 1'b0, "R1 full", 32'(wr_full), 32'h0);
        chk(mreq_valid == 1'b0, "R1 valid", 32'(mreq_valid), 32'h0);
        chk(err_sticky == 1'b0, "R1 err", 32'(err_sticky), 32'h0);

        // R9: response with error while nothing is outstanding
        respond(1'b1);
        @(negedge clk);
        chk(err_sticky == 1'b0, "R9 stray response", 32'(err_sticky), 32'h0);
        chk(buf_empty == 1'b1, "R9 still empty", 32'(buf_empty), 32'h1);

        // R3: four rising words of one line form one full-line burst
        mreq_ready = 1'b1;
        for (int i = 0; i < 4; i++) put(32'h1000 + 32'(4*i));
        wait_burst(n);
        chk(n == 4, "R3 rising line burst", 32'(n), 32'h4);
        respond(1'b0);

        // R3: falling word index splits the group
        put(32'h1008);
        put(32'h1004);
        wait_burst(n);
        chk(n == 1, "R3 falling word splits", 32'(n), 32'h1);
        respond(1'b0);
        wait_burst(n);
        chk(n == 1, "R3 second group", 32'(n), 32'h1);
        respond(1'b0);

        // R11: fill with alternating lines, hold the response
        for (int i = 0; i < DEPTH; i++) put(32'h3000 + 32'((i % 2) * 16));
        wait_burst(n);
        chk(n == 1, "R3 line change splits", 32'(n), 32'h1);
        repeat (4) @(negedge clk);
        chk(wr_full == 1'b1, "R11 full while awaiting", 32'(wr_full), 32'h1);
        chk(mreq_valid == 1'b0, "R6 no second burst", 32'(mreq_valid), 32'h0);
        respond(1'b0);
        chk(wr_full == 1'b0, "R11 released on response", 32'(wr_full), 32'h0);
        drain();

        // R8: error response latches and still retires
        put(32'h4000);
        wait_burst(n);
        @(negedge clk);
        mrsp_valid = 1'b1;
        mrsp_err   = 1'b1;
        @(negedge clk);
        mrsp_valid = 1'b0;
        mrsp_err   = 1'b0;
        chk(err_sticky == 1'b1, "R8 error latched", 32'(err_sticky), 32'h1);
        chk(buf_empty == 1'b1, "R8 entry retired", 32'(buf_empty), 32'h1);
        repeat (3) @(negedge clk);
        chk(err_sticky == 1'b1, "R8 error sticky", 32'(err_sticky), 32'h1);

        // random traffic over three lines, with stalls and stray responses
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            wr_valid   = ($urandom % 10) < 6;
            wr_addr    = 32'h2000 + 32'(($urandom % 3) * 16) + 32'(($urandom % 4) * 4) + 32'($urandom % 4);
            wr_data    = $urandom;
            wr_be      = 4'($urandom);
            mreq_ready = ($urandom % 10) < 7;
            mrsp_valid = ($urandom % 10) < 3;
            mrsp_err   = ($urandom % 10) == 0;
        end
        drain();

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 100000);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule